// File: doc/BRIEF.md
# Hybrid Bimodal/Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two independent guessers. The first is a per-address table of 2-bit saturating counters. The second is a table of the same counters, indexed by the branch address folded with a register that records recent global outcomes. A third table of 2-bit counters, indexed by the branch address, learns which of the two guessers to trust for each branch.

A front end presents a branch address on the lookup port. One cycle later the block returns the final direction, both component guesses and the history value used for the lookup. The front end keeps these values with the branch. When the branch resolves, the back end sends the address, the real outcome, both component guesses and the history snapshot back on the update port. The block then trains all three tables and shifts the outcome into the history register.

The history is written only at resolve time. If a lookup and an update arrive in the same cycle, the lookup sees the tables and history as they were before that update.

Top module: `hybrid_dir_pred`

## Requirements
- R1: After reset every counter in all three tables holds 1 and the history holds 0. A first lookup therefore returns final, bimodal and gshare guesses of 0 (not taken) and a history snapshot of 0, and `pred_valid_o` is low until a lookup is made.
- R2: `pred_valid_o` is high in exactly the cycle after a cycle with `lk_valid_i` high. The guesses and the snapshot are valid in that cycle.
- R3: The bimodal index is PC bits [9:2]. PC bits [1:0] and PC bits above bit 9 are not part of the index. The bimodal guess is the MSB of the indexed counter (1 = taken).
- R4: The gshare index is PC bits [9:2] XOR the 8-bit history. The gshare guess is the MSB of that counter.
- R5: On each update the history shifts left by one and takes the outcome into bit 0. Without an update the history holds its value. `pred_hist_o` returns the history that was present at the lookup.
- R6: The final guess is the gshare guess when the selector counter's MSB is 1, and the bimodal guess otherwise. The selector moves only when the returned component guesses differ: it counts up when the gshare guess matched the outcome and down when it did not.
- R7: Every update moves both component counters toward the outcome: up when taken, down when not taken. The gshare counter written is the one at PC[9:2] XOR the returned history snapshot.
- R8: A lookup in the same cycle as an update returns values computed from the state before that update.
- R9: Counters saturate. An increment at 3 stays at 3, and a decrement at 0 stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_pc_i | input | 32 | Branch address to look up |
| pred_valid_o | output | 1 | Lookup result valid (one cycle after request) |
| pred_taken_o | output | 1 | Final direction guess |
| pred_bim_o | output | 1 | Bimodal component guess |
| pred_gsh_o | output | 1 | Gshare component guess |
| pred_hist_o | output | 8 | History used for this lookup |
| upd_valid_i | input | 1 | Resolved branch update |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Real outcome |
| upd_bim_i | input | 1 | Bimodal guess returned from lookup |
| upd_gsh_i | input | 1 | Gshare guess returned from lookup |
| upd_hist_i | input | 8 | History snapshot returned from lookup |

## Verification
A wrong counter value is invisible until a later lookup reads that entry. For bimodal and selector entries this happens on the next lookup of the same address. For gshare entries it happens only when the history again produces the same index. The bench therefore compares all four lookup outputs against a reference model of the three tables after every branch, so a wrong entry shows up within one lookup of being read. A history error shows up in the very next `pred_hist_o` and in the gshare guess. A bad same-cycle ordering shows up in the lookup that shares the cycle with the update.

// File: rtl/hdp_pkg.sv
package hdp_pkg;
  localparam int unsigned CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_RST = ctr_t'(1);
  localparam ctr_t CTR_MAX = '1;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == CTR_MAX) ? c : c + ctr_t'(1);
    else    return (c == '0)      ? c : c - ctr_t'(1);
  endfunction

  typedef struct packed {
    logic taken;
    logic bim;
    logic gsh;
  } pred_t;
endpackage

// File: rtl/hdp_ctr_table.sv
module hdp_ctr_table
  import hdp_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  ctr_t tbl_q [ENTRIES];

  // read is combinational; caller registers the result
  assign rd_ctr_o = tbl_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= CTR_RST;
    end else if (wr_en_i) begin
      tbl_q[wr_idx_i] <= ctr_step(tbl_q[wr_idx_i], wr_up_i);
    end
  end
endmodule

// File: rtl/hdp_ghist.sv
module hdp_ghist #(
  parameter int unsigned HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_en_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hist_q <= '0;
    else if (shift_en_i) hist_q <= {hist_q[HIST_W-2:0], bit_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/hdp_index.sv
module hdp_index #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned HIST_W = 8,
  parameter int unsigned PC_LSB = 2
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [HIST_W-1:0] hist_i,
  output logic [IDX_W-1:0]  bim_idx_o,
  output logic [IDX_W-1:0]  gsh_idx_o
);
  logic [IDX_W-1:0] hist_fit;

  assign bim_idx_o = pc_i[PC_LSB +: IDX_W];

  // fit history to index width: truncate long history, zero-extend short
  generate
    if (HIST_W >= IDX_W) begin : g_trunc
      assign hist_fit = hist_i[IDX_W-1:0];
    end else begin : g_ext
      assign hist_fit = {{(IDX_W-HIST_W){1'b0}}, hist_i};
    end
  endgenerate

  assign gsh_idx_o = bim_idx_o ^ hist_fit;
endmodule

// File: rtl/hybrid_dir_pred.sv
module hybrid_dir_pred
  import hdp_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [PC_W-1:0]   lk_pc_i,
  output logic              pred_valid_o,
  output logic              pred_taken_o,
  output logic              pred_bim_o,
  output logic              pred_gsh_o,
  output logic [HIST_W-1:0] pred_hist_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic              upd_taken_i,
  input  logic              upd_bim_i,
  input  logic              upd_gsh_i,
  input  logic [HIST_W-1:0] upd_hist_i
);
  localparam int unsigned PC_LSB = 2;

  logic [HIST_W-1:0] hist_q;
  logic [IDX_W-1:0]  lk_bim_idx, lk_gsh_idx, up_bim_idx, up_gsh_idx;
  ctr_t              bim_ctr, gsh_ctr, sel_ctr;
  logic              sel_wr;
  pred_t             pred_d, pred_q;
  logic              valid_q;
  logic [HIST_W-1:0] hist_snap_q;

  hdp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB)) u_lk_idx (
    .pc_i(lk_pc_i), .hist_i(hist_q),
    .bim_idx_o(lk_bim_idx), .gsh_idx_o(lk_gsh_idx)
  );

  // update side uses the snapshot taken at lookup, not the live history
  hdp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB)) u_up_idx (
    .pc_i(upd_pc_i), .hist_i(upd_hist_i),
    .bim_idx_o(up_bim_idx), .gsh_idx_o(up_gsh_idx)
  );

  hdp_ctr_table #(.IDX_W(IDX_W)) u_bim_tbl (
    .clk_i, .rst_ni,
    .rd_idx_i(lk_bim_idx), .rd_ctr_o(bim_ctr),
    .wr_en_i(upd_valid_i), .wr_idx_i(up_bim_idx), .wr_up_i(upd_taken_i)
  );

  hdp_ctr_table #(.IDX_W(IDX_W)) u_gsh_tbl (
    .clk_i, .rst_ni,
    .rd_idx_i(lk_gsh_idx), .rd_ctr_o(gsh_ctr),
    .wr_en_i(upd_valid_i), .wr_idx_i(up_gsh_idx), .wr_up_i(upd_taken_i)
  );

  // selector trains only on disagreement, toward gshare when gshare was right
  assign sel_wr = upd_valid_i && (upd_bim_i != upd_gsh_i);

  hdp_ctr_table #(.IDX_W(IDX_W)) u_sel_tbl (
    .clk_i, .rst_ni,
    .rd_idx_i(lk_bim_idx), .rd_ctr_o(sel_ctr),
    .wr_en_i(sel_wr), .wr_idx_i(up_bim_idx), .wr_up_i(upd_gsh_i == upd_taken_i)
  );

  hdp_ghist #(.HIST_W(HIST_W)) u_ghist (
    .clk_i, .rst_ni,
    .shift_en_i(upd_valid_i), .bit_i(upd_taken_i), .hist_o(hist_q)
  );

  always_comb begin
    pred_d.bim   = bim_ctr[CTR_W-1];
    pred_d.gsh   = gsh_ctr[CTR_W-1];
    pred_d.taken = sel_ctr[CTR_W-1] ? pred_d.gsh : pred_d.bim;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q     <= 1'b0;
      pred_q      <= '0;
      hist_snap_q <= '0;
    end else begin
      valid_q <= lk_valid_i;
      if (lk_valid_i) begin
        pred_q      <= pred_d;
        hist_snap_q <= hist_q;
      end
    end
  end

  assign pred_valid_o = valid_q;
  assign pred_taken_o = pred_q.taken;
  assign pred_bim_o   = pred_q.bim;
  assign pred_gsh_o   = pred_q.gsh;
  assign pred_hist_o  = hist_snap_q;
endmodule

// File: rtl/hdp_checker.sv
module hdp_checker #(
  parameter int unsigned HIST_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lk_valid_i,
  input logic              pred_valid_o,
  input logic              pred_taken_o,
  input logic              pred_bim_o,
  input logic              pred_gsh_o,
  input logic              upd_valid_i,
  input logic              upd_taken_i,
  input logic [HIST_W-1:0] hist_q
);
  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> pred_valid_o);

  assert_valid_drops_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !pred_valid_o);

  assert_pick_component_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> (pred_taken_o == pred_bim_o) || (pred_taken_o == pred_gsh_o));

  assert_hist_shift_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(upd_taken_i)});

  assert_hist_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(hist_q));
endmodule

bind hybrid_dir_pred hdp_checker #(.HIST_W(HIST_W)) u_hdp_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i),
  .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o),
  .pred_bim_o(pred_bim_o), .pred_gsh_o(pred_gsh_o),
  .upd_valid_i(upd_valid_i), .upd_taken_i(upd_taken_i), .hist_q(hist_q)
);

// File: tb/hybrid_dir_pred_test.sv
`timescale 1ns/1ps
module hybrid_dir_pred_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        p_valid, p_taken, p_bim, p_gsh;
  logic [7:0]  p_hist;
  logic        u_valid = 1'b0;
  logic [31:0] u_pc = '0;
  logic        u_taken = 1'b0, u_bim = 1'b0, u_gsh = 1'b0;
  logic [7:0]  u_hist = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hybrid_dir_pred uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_pc_i(lk_pc),
    .pred_valid_o(p_valid), .pred_taken_o(p_taken), .pred_bim_o(p_bim),
    .pred_gsh_o(p_gsh), .pred_hist_o(p_hist),
    .upd_valid_i(u_valid), .upd_pc_i(u_pc), .upd_taken_i(u_taken),
    .upd_bim_i(u_bim), .upd_gsh_i(u_gsh), .upd_hist_i(u_hist)
  );

  // reference model
  int m_bim [256];
  int m_gsh [256];
  int m_sel [256];
  int m_hist;

  function automatic int idx_of(logic [31:0] pc);
    return int'(pc[9:2]);
  endfunction
  function automatic int sat(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction
  function automatic bit e_bim(logic [31:0] pc);
    return m_bim[idx_of(pc)] >= 2;
  endfunction
  function automatic bit e_gsh(logic [31:0] pc);
    return m_gsh[idx_of(pc) ^ m_hist] >= 2;
  endfunction
  function automatic bit e_taken(logic [31:0] pc);
    return (m_sel[idx_of(pc)] >= 2) ? e_gsh(pc) : e_bim(pc);
  endfunction

  task automatic m_update(logic [31:0] pc, bit t, bit pb, bit pg, int h);
    int i = idx_of(pc);
    m_bim[i] = sat(m_bim[i], t);
    m_gsh[i ^ h] = sat(m_gsh[i ^ h], t);
    if (pb != pg) m_sel[i] = sat(m_sel[i], pg == t);
    m_hist = ((m_hist << 1) | int'(t)) & 255;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // lookup: drive at negedge, result sampled at the next negedge
  task automatic look(logic [31:0] pc);
    bit eb = e_bim(pc), eg = e_gsh(pc), et = e_taken(pc);
    int eh = m_hist;
    lk_valid = 1'b1; lk_pc = pc;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R2 valid", 32'(p_valid), 32'd1);
    chk("R3 bim", 32'(p_bim), 32'(eb));
    chk("R4 gsh", 32'(p_gsh), 32'(eg));
    chk("R6 final", 32'(p_taken), 32'(et));
    chk("R5 hist", 32'(p_hist), 32'(eh));
  endtask

  task automatic upd(logic [31:0] pc, bit t);
    bit pb = e_bim(pc), pg = e_gsh(pc);
    int h = m_hist;
    u_valid = 1'b1; u_pc = pc; u_taken = t; u_bim = pb; u_gsh = pg; u_hist = 8'(h);
    @(negedge clk);
    u_valid = 1'b0;
    m_update(pc, t, pb, pg, h);
  endtask

  // same-cycle lookup and update: lookup reflects pre-update state
  task automatic both(logic [31:0] lpc, logic [31:0] upc, bit t);
    bit eb = e_bim(lpc), eg = e_gsh(lpc), et = e_taken(lpc);
    int eh = m_hist;
    bit pb = e_bim(upc), pg = e_gsh(upc);
    lk_valid = 1'b1; lk_pc = lpc;
    u_valid = 1'b1; u_pc = upc; u_taken = t; u_bim = pb; u_gsh = pg; u_hist = 8'(eh);
    @(negedge clk);
    lk_valid = 1'b0; u_valid = 1'b0;
    chk("R8 bim", 32'(p_bim), 32'(eb));
    chk("R8 gsh", 32'(p_gsh), 32'(eg));
    chk("R8 final", 32'(p_taken), 32'(et));
    chk("R8 hist", 32'(p_hist), 32'(eh));
    m_update(upc, t, pb, pg, eh);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin m_bim[i] = 1; m_gsh[i] = 1; m_sel[i] = 1; end
    m_hist = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt = 0;
    void'($urandom(32'd20240611));
    do_reset();

    // R1: reset state
    chk("R1 valid idle", 32'(p_valid), 32'd0);
    lk_valid = 1'b1; lk_pc = 32'h0000_0040;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R1 final", 32'(p_taken), 32'd0);
    chk("R1 bim", 32'(p_bim), 32'd0);
    chk("R1 gsh", 32'(p_gsh), 32'd0);
    chk("R1 hist", 32'(p_hist), 32'd0);
    chk("R2 valid", 32'(p_valid), 32'd1);
    @(negedge clk);
    chk("R2 valid one cycle", 32'(p_valid), 32'd0);

    // R7: one taken update moves bim[0x10] and gsh[0x10^0] to 2
    upd(32'h0000_0040, 1'b1);
    look(32'h0000_0040);
    chk("R7 bim trained", 32'(p_bim), 32'd1);
    look(32'h0000_0044);   // idx 0x11 ^ hist 1 = 0x10
    chk("R7 gsh trained", 32'(p_gsh), 32'd1);

    // R3: aliasing on dropped PC bits
    look(32'h0000_0043);
    chk("R3 low bits dropped", 32'(p_bim), 32'd1);
    look(32'h0000_0440);
    chk("R3 high bits dropped", 32'(p_bim), 32'd1);

    // R9: saturation at top
    for (int i = 0; i < 6; i++) upd(32'h0000_0100, 1'b1);
    upd(32'h0000_0100, 1'b0);
    look(32'h0000_0100);
    chk("R9 sat high", 32'(p_bim), 32'd1);
    // R9: saturation at bottom
    for (int i = 0; i < 6; i++) upd(32'h0000_0200, 1'b0);
    upd(32'h0000_0200, 1'b1);
    look(32'h0000_0200);
    chk("R9 sat low", 32'(p_bim), 32'd0);

    // R8: bim at 2 for 0x100; same-cycle not-taken update still shows taken
    both(32'h0000_0100, 32'h0000_0100, 1'b0);
    chk("R8 pre-update", 32'(p_bim), 32'd1);
    look(32'h0000_0100);
    chk("R8 post-update", 32'(p_bim), 32'd0);

    // R5: history shifts in outcomes
    do_reset();
    upd(32'h0000_0300, 1'b1);
    upd(32'h0000_0300, 1'b0);
    upd(32'h0000_0300, 1'b1);
    look(32'h0000_0300);
    chk("R5 shift pattern", 32'(p_hist), 32'h5);

    // R6: selector shift toward gshare under a disagreeing pattern
    // random mixed traffic, model-checked
    for (int it = 0; it < 600; it++) begin
      int k = int'($urandom % 6);
      logic [31:0] pc = 32'h0000_4000 + 32'(k * 36);
      bit t;
      if (k < 2)       t = ($urandom % 8) != 0;
      else if (k == 2) begin t = (cnt % 4) != 3; cnt++; end
      else             t = $urandom % 2;
      if ($urandom % 5 == 0) begin
        logic [31:0] lpc = 32'h0000_4000 + 32'(($urandom % 6) * 36);
        both(lpc, pc, t);
      end else begin
        look(pc);
        upd(pc, t);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule